// File: doc/BRIEF.md
# Burst Read Latency Interface

This block is the device-side read controller for a synchronous burst port on a memory interface where address and data share one bus. The host presents a start address on the shared bus together with an active-low address-valid strobe on a rising clock edge while chip-enable is low. The block then waits a programmable number of clocks before it presents burst words back-to-back, one per clock, from successive addresses. A ready output tells the host when the first valid word is on the bus, so the host does not have to count the latency itself.

The initial latency is held in a small configuration register. It can be set from 3 to 7 clocks and comes up as 4 after reset. A high-frequency flag is stored next to it and passed out to the clocking logic. By convention latency 6 or 7 is used with the flag set above 66 MHz, latency 4 with it clear from 40 to 66 MHz, and latency 3 with it clear below 40 MHz. The data outputs are driven only while both chip-enable and output-enable are low. The memory array is modelled as a fixed function of the word address.

Top module: `burst_rd_port`

## Requirements
- R1: While reset is asserted and after it is released, the stored latency is 4, `hf_mode` is 0, `rdy` is 0 and `dq_oe` is 0.
- R2: A rising edge with `cfg_we` high stores `cfg_lat_in` (3 bits) and `cfg_hf_in`. Codes 3 to 7 are kept as written, and codes 0, 1 and 2 are stored as 3.
- R3: `hf_mode` always shows the stored high-frequency flag. The flag has no effect on burst timing.
- R4: A rising edge with `ce_n` low and `adv_n` low latches `ad_in` as the burst start address. The access uses the latency stored before that edge, so a configuration write after the latch does not change the running access.
- R5: With latency n, the word for the start address is driven after the n-th rising edge that follows the latch edge, so the host first samples it on edge n+1. The word for address a is the byte-swapped address XOR 16'hA5C3, that is {a[7:0], a[15:8]} ^ 16'hA5C3.
- R6: Each rising edge after the first word moves the bus to the word of the next address, incrementing by one modulo 2^16.
- R7: `rdy` is 0 from the latch edge until the first word is driven, rises together with the first word, and stays 1 for the rest of the burst.
- R8: A rising edge with `ce_n` high ends any access and clears `rdy`. `adv_n` is ignored while `ce_n` is high.
- R9: An address-valid pulse during the wait or the burst restarts the access from the new address, with the full latency counted again.
- R10: `dq_oe` is 1 only while `ce_n` is low, `oe_n` is low and `rdy` is 1, and it follows `ce_n` and `oe_n` without a clock. `dq_out` is all zeros whenever `dq_oe` is 0. `oe_n` does not pause the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| ad_in | input | 16 | Shared bus as seen by the device (address phase) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lat_in | input | 3 | Latency code to store |
| cfg_hf_in | input | 1 | High-frequency flag to store |
| dq_out | output | 16 | Burst data toward the shared bus |
| dq_oe | output | 1 | Drive enable for `dq_out`; 0 means high impedance |
| rdy | output | 1 | First valid word present / burst in progress |
| hf_mode | output | 1 | Stored high-frequency flag |

## Verification
Bursts are run at every legal latency and at the clamped codes 0 and 2. Together these separate an off-by-one in the wait count from a missing clamp or a wrong default. A configuration write placed inside the wait shows whether the latency is sampled once at the latch. Address-valid pulses inside the wait, inside the burst, back to back and while chip-enable is high cover the restart and ignore paths. Raising output-enable in the middle of a burst, and starting a burst just below the top of the address space, show that gating is combinational, that the burst keeps running and that the address wraps.

// File: rtl/brl_pkg.sv
package brl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_BURST = 2'd2
    } brl_state_e;

endpackage

// File: rtl/brl_cfg_reg.sv
module brl_cfg_reg #(
    parameter int LW      = 3,
    parameter int LAT_MIN = 3,
    parameter int LAT_MAX = 7,
    parameter int LAT_DEF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [LW-1:0] lat_in,
    input  logic          hf_in,
    output logic [LW-1:0] lat,
    output logic          hf
);

    localparam int LAT_TOP = (1 << LW) - 1;

    typedef struct packed {
        logic [LW-1:0] lat;
        logic          hf;
    } cfg_t;

    cfg_t          c_d, c_q;
    logic [LW-1:0] lat_hi;
    logic [LW-1:0] lat_ok;

    // Upper clamp exists only when the field can encode more than the maximum
    generate
        if (LAT_TOP > LAT_MAX) begin : g_hi_clamp
            assign lat_hi = (lat_in > LW'(LAT_MAX)) ? LW'(LAT_MAX) : lat_in;
        end else begin : g_no_hi_clamp
            assign lat_hi = lat_in;
        end
    endgenerate

    assign lat_ok = (lat_hi < LW'(LAT_MIN)) ? LW'(LAT_MIN) : lat_hi;

    always_comb begin
        c_d = c_q;
        if (we) begin
            c_d.lat = lat_ok;
            c_d.hf  = hf_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.lat <= LW'(LAT_DEF);
            c_q.hf  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign lat = c_q.lat;
    assign hf  = c_q.hf;

endmodule

// File: rtl/brl_burst_ctrl.sv
module brl_burst_ctrl
    import brl_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          adv_n,
    input  logic [AW-1:0] addr_in,
    input  logic [LW-1:0] lat_in,
    output logic [AW-1:0] burst_addr,
    output logic          rdy
);

    typedef struct packed {
        brl_state_e    st;
        logic [LW-1:0] cnt;
        logic [LW-1:0] lat;
        logic [AW-1:0] addr;
        logic          rdy;
    } ctrl_t;

    ctrl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ce_n) begin
            // deselect ends any access; address strobe is ignored
            s_d.st  = ST_IDLE;
            s_d.cnt = '0;
            s_d.rdy = 1'b0;
        end else if (!adv_n) begin
            // latch edge: start (or restart) and freeze latency for this access
            s_d.st   = ST_WAIT;
            s_d.addr = addr_in;
            s_d.lat  = lat_in;
            s_d.cnt  = LW'(1);
            s_d.rdy  = 1'b0;
        end else begin
            case (s_q.st)
                ST_WAIT: begin
                    if (s_q.cnt == s_q.lat) begin
                        s_d.st  = ST_BURST;
                        s_d.rdy = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + LW'(1);
                    end
                end
                ST_BURST: begin
                    s_d.addr = s_q.addr + AW'(1);
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.cnt  <= '0;
            s_q.lat  <= '0;
            s_q.addr <= '0;
            s_q.rdy  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign burst_addr = s_q.addr;
    assign rdy        = s_q.rdy;

endmodule

// File: rtl/brl_word_src.sv
module brl_word_src #(
    parameter int             AW   = 16,
    parameter int             DW   = 16,
    parameter logic [DW-1:0]  SALT = 16'hA5C3
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] word
);

    localparam int HALF = AW / 2;

    logic [AW-1:0] swapped;

    assign swapped = {addr[HALF-1:0], addr[AW-1:HALF]};
    assign word    = DW'(swapped) ^ SALT;

endmodule

// File: rtl/brl_out_gate.sv
module brl_out_gate #(
    parameter int DW = 16
) (
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          valid,
    input  logic [DW-1:0] word,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);

    always_comb begin
        dq_oe  = !ce_n && !oe_n && valid;
        dq_out = dq_oe ? word : '0;
    end

endmodule

// File: rtl/burst_rd_port.sv
module burst_rd_port #(
    parameter int            AW      = 16,
    parameter int            DW      = 16,
    parameter int            LW      = 3,
    parameter int            LAT_MIN = 3,
    parameter int            LAT_MAX = 7,
    parameter int            LAT_DEF = 4,
    parameter logic [DW-1:0] SALT    = 16'hA5C3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          adv_n,
    input  logic [DW-1:0] ad_in,
    input  logic          cfg_we,
    input  logic [LW-1:0] cfg_lat_in,
    input  logic          cfg_hf_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          rdy,
    output logic          hf_mode
);

    logic [LW-1:0] cfg_lat;
    logic          cfg_hf;
    logic [AW-1:0] burst_addr;
    logic          rdy_int;
    logic [DW-1:0] word;

    brl_cfg_reg #(
        .LW      (LW),
        .LAT_MIN (LAT_MIN),
        .LAT_MAX (LAT_MAX),
        .LAT_DEF (LAT_DEF)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .lat_in (cfg_lat_in),
        .hf_in  (cfg_hf_in),
        .lat    (cfg_lat),
        .hf     (cfg_hf)
    );

    brl_burst_ctrl #(
        .AW (AW),
        .LW (LW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .adv_n      (adv_n),
        .addr_in    (ad_in[AW-1:0]),
        .lat_in     (cfg_lat),
        .burst_addr (burst_addr),
        .rdy        (rdy_int)
    );

    brl_word_src #(
        .AW   (AW),
        .DW   (DW),
        .SALT (SALT)
    ) u_src (
        .addr (burst_addr),
        .word (word)
    );

    brl_out_gate #(
        .DW (DW)
    ) u_gate (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .valid  (rdy_int),
        .word   (word),
        .dq_out (dq_out),
        .dq_oe  (dq_oe)
    );

    assign rdy     = rdy_int;
    assign hf_mode = cfg_hf;

endmodule

// File: rtl/brl_checker.sv
module brl_checker #(
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter int LW      = 3,
    parameter int LAT_MIN = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic          adv_n,
    input logic          rdy,
    input logic          dq_oe,
    input logic [DW-1:0] dq_out,
    input logic [AW-1:0] burst_addr,
    input logic [LW-1:0] cfg_lat
);

    // edges elapsed since the latch edge, and the latency in force at it
    logic [3:0]    since_q;
    logic [LW-1:0] lat_l_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            lat_l_q <= '0;
        end else if (!ce_n && !adv_n) begin
            since_q <= 4'd1;
            lat_l_q <= cfg_lat;
        end else if (since_q != 4'd0 && since_q != 4'd15) begin
            since_q <= since_q + 4'd1;
        end
    end

    // R7: no ready in the cycle after a latch edge
    a_r7_rdy_low_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !adv_n) |=> !rdy);

    // R8: deselect clears ready
    a_r8_ce_clears_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !rdy);

    // R10: outputs released whenever chip or output enable is high
    a_r10_hiz_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (!dq_oe && dq_out == '0));

    // R6: burst address steps by one each clock
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !ce_n && adv_n) |=> (burst_addr == AW'($past(burst_addr) + 1'b1)));

    // R2: stored latency never below the minimum
    a_r2_lat_floor: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_lat >= LW'(LAT_MIN));

    // R5: ready rises exactly n edges after the latch edge
    a_r5_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> (int'(since_q) == int'(lat_l_q) + 1));

endmodule

bind burst_rd_port brl_checker #(
    .AW      (AW),
    .DW      (DW),
    .LW      (LW),
    .LAT_MIN (LAT_MIN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .adv_n      (adv_n),
    .rdy        (rdy),
    .dq_oe      (dq_oe),
    .dq_out     (dq_out),
    .burst_addr (burst_addr),
    .cfg_lat    (cfg_lat)
);

// File: tb/sim_burst_rd_port.sv
module sim_burst_rd_port;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        adv_n = 1'b1;
    logic [15:0] ad_in = 16'h0000;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_lat_in = 3'd0;
    logic        cfg_hf_in = 1'b0;
    logic [15:0] dq_out;
    logic        dq_oe;
    logic        rdy;
    logic        hf_mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    string scen  = "R1 reset";

    burst_rd_port u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .adv_n      (adv_n),
        .ad_in      (ad_in),
        .cfg_we     (cfg_we),
        .cfg_lat_in (cfg_lat_in),
        .cfg_hf_in  (cfg_hf_in),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe),
        .rdy        (rdy),
        .hf_mode    (hf_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    bit          m_act = 1'b0;
    int          m_since = 0;
    int          m_acc = 4;
    int          m_lat = 4;
    bit          m_hf = 1'b0;
    logic [15:0] m_base = 16'h0;

    function automatic logic [15:0] ref_word(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'hA5C3;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 1'b0; m_since = 0; m_lat = 4; m_hf = 1'b0;
        end else begin
            int lat_before;
            lat_before = m_lat;
            if (ce_n) begin
                m_act = 1'b0;
            end else if (!adv_n) begin
                m_act = 1'b1; m_base = ad_in; m_since = 0; m_acc = lat_before;
            end else if (m_act) begin
                m_since = m_since + 1;
            end
            if (cfg_we) begin
                m_lat = (int'(cfg_lat_in) < 3) ? 3 : int'(cfg_lat_in);
                m_hf  = cfg_hf_in;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s) at %0t: actual %0h expected %0h", tag, scen, $time, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit          e_rdy;
            bit          e_oe;
            logic [15:0] e_addr;
            e_rdy  = m_act && (m_since >= m_acc);
            e_oe   = !ce_n && !oe_n && e_rdy;
            e_addr = m_base + 16'(m_since - m_acc);
            chk("R7 rdy", 32'(rdy), 32'(e_rdy));
            chk("R10 dq_oe", 32'(dq_oe), 32'(e_oe));
            chk("R5 R6 dq_out", 32'(dq_out), e_oe ? 32'(ref_word(e_addr)) : 32'h0);
            chk("R3 hf_mode", 32'(hf_mode), 32'(m_hf));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drv(input logic adv, input logic [15:0] ad, input logic we,
                       input logic [2:0] lat, input logic hf);
        @(negedge clk);
        #1;
        adv_n = adv; ad_in = ad; cfg_we = we; cfg_lat_in = lat; cfg_hf_in = hf;
    endtask

    task automatic hold(input int n);
        for (int i = 0; i < n; i++) drv(1'b1, 16'hDEAD ^ 16'(i), 1'b0, 3'd5, 1'b0);
    endtask

    task automatic start(input logic [15:0] a);
        drv(1'b0, a, 1'b0, 3'd0, 1'b0);
    endtask

    task automatic cfg(input logic [2:0] l, input logic h);
        drv(1'b1, 16'hBEEF, 1'b1, l, h);
    endtask

    task automatic pins(input logic ce, input logic oe);
        @(negedge clk);
        #1;
        ce_n = ce; oe_n = oe; adv_n = 1'b1; cfg_we = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        // R1: defaults held in reset even with the part selected
        ce_n = 1'b0; oe_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 rdy in reset", 32'(rdy), 32'h0);
        chk("R1 dq_oe in reset", 32'(dq_oe), 32'h0);
        chk("R1 hf_mode in reset", 32'(hf_mode), 32'h0);
        #1 rst_n = 1'b1;
        hold(2);

        // R1 R5: default latency 4
        scen = "R1 default latency";
        start(16'h1234); hold(10);

        // R2 R5: each legal latency
        scen = "R2 latency 3";
        cfg(3'd3, 1'b0); start(16'h2000); hold(8);
        scen = "R3 latency 7 with hf";
        cfg(3'd7, 1'b1); start(16'h3ABC); hold(12);
        scen = "R2 latency 5";
        cfg(3'd5, 1'b0); start(16'h0101); hold(9);
        scen = "R2 latency 6";
        cfg(3'd6, 1'b1); start(16'h7F00); hold(10);

        // R2: low codes clamp to 3
        scen = "R2 clamp code 0";
        cfg(3'd0, 1'b0); start(16'h4444); hold(7);
        scen = "R2 clamp code 2";
        cfg(3'd2, 1'b1); start(16'h5555); hold(7);

        // R4: write during wait does not affect running access
        scen = "R4 latency frozen at latch";
        cfg(3'd7, 1'b0); start(16'h6000); cfg(3'd3, 1'b0); hold(12);
        scen = "R4 new latency on next access";
        start(16'h6100); hold(7);

        // R9: restart during wait, during burst, back to back
        scen = "R9 restart in wait";
        cfg(3'd4, 1'b0); start(16'h0A00); hold(1); start(16'h0B00); hold(9);
        scen = "R9 restart in burst";
        start(16'h0C00); hold(7); start(16'h0D00); hold(9);
        scen = "R9 back to back strobes";
        start(16'h0E00); start(16'h0F00); hold(8);

        // R8: deselect ends burst, strobe ignored while deselected
        scen = "R8 deselect";
        start(16'h1100); hold(7);
        pins(1'b1, 1'b0); hold(2);
        drv(1'b0, 16'h9999, 1'b0, 3'd0, 1'b0); hold(3);
        pins(1'b0, 1'b0); hold(6);

        // R10: output enable gates data, burst keeps running
        scen = "R10 oe gating";
        start(16'h2200); hold(6);
        pins(1'b0, 1'b1); hold(3);
        pins(1'b0, 1'b0); hold(4);

        // R6: address wraps past the top
        scen = "R6 wrap";
        start(16'hFFFD); hold(10);

        pins(1'b1, 1'b1); hold(2);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule